// File: doc/BRIEF.md
# Fractional Divide Delta-Sigma Modulator

This block produces the divide value for a feedback counter. The value changes from update to update, and over time its average is an integer multiplier plus a fraction K / 2^W. The accumulator width W is chosen from 8, 16, 24 or 32 bits. A cascade of up to three accumulators shapes the quantisation error. Each accumulator overflow yields a carry, and those carries are combined through first and second differences into a small signed offset. The block adds that offset to the integer multiplier and clamps the result so it never falls below 1.

The consumer paces the block through a single update strobe. Every strobe sampled high produces exactly one new divide value, and that value appears with a valid pulse one clock later. The output has no ready signal and the consumer cannot apply back-pressure. The feedback counter must accept each value in the cycle its valid pulse is high. Between pulses the output holds its last value. The configuration inputs (width and order) are plain control pins. Any change to them clears the whole modulator state.

Top module: `fdsm_divmod`

## Requirements
- R1: `div_vld_o` is high in exactly the cycle after a cycle in which `upd_i` was sampled high, and low otherwise. `div_o` changes only with that pulse and holds its value while no update occurs.
- R2: `wsel_i` selects the accumulator width W: 0 gives 8, 1 gives 16, 2 gives 24, 3 gives 32 bits. Bits of `frac_k_i` at or above W are ignored, and every accumulator stays masked to W bits.
- R3: `order_i` = 0 turns shaping off. Every update then yields `div_o` equal to `int_mult_i`.
- R4: With `order_i` = 1, each output is N or N+1, where N is `int_mult_i`. Starting from a cleared state, the sum of 2^W consecutive outputs is exactly N·2^W + (K mod 2^W).
- R5: The offset `div_o` − N stays within 0..+1 for order 1, within −1..+2 for order 2 (code 2), and within −3..+4 for order 3 (code 3). This holds as long as no clamping occurs.
- R6: For order 2 and order 3 the outputs follow a fixed recurrence, evaluated per update:
  - Accumulator a1 takes K; a2 takes the new a1; a3 takes the new a2. Each addition is taken mod 2^W and produces carries c1, c2 and c3.
  - The offset is c1 + (c2 − c2′) for order 2, where a prime marks the value from the previous update.
  - The offset is c1 + (c2 − c2′) + (c3 − 2·c3′ + c3″) for order 3.
  - All history starts at zero.
- R7: A change of `wsel_i` or `order_i` clears all accumulators and carry history. The next update then behaves as the first update after reset.
- R8: If N plus the offset would be below 1, `div_o` is 1.
- R9: After reset `div_vld_o` is 0 and `div_o` is 0.
- R10: The full range N = 1..512 is carried without loss, including the largest value with a positive offset added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | Update strobe, one new divide value per sampled high cycle |
| int_mult_i | input | INT_W (10) | Integer multiplier N, 1..512 |
| frac_k_i | input | ACC_W (32) | Fraction numerator K, masked to the selected width |
| wsel_i | input | 2 | Accumulator width code (8/16/24/32 bits) |
| order_i | input | 2 | Shaping order code: 0 off, 1..3 order |
| div_o | output | INT_W (10) | Instantaneous divide value |
| div_vld_o | output | 1 | One-cycle pulse marking a new `div_o` |

## Verification
Every result is due exactly one clock after the edge that samples `upd_i` high. The bench therefore raises the strobe at a falling edge and reads `div_o` and `div_vld_o` at the next falling edge, half a cycle after the registering edge. Checks that something holds still span several idle cycles and compare against the value captured after the last pulse. A configuration change is applied with the strobe low and takes effect at the next edge. The bench leaves at least one idle cycle before the next update, so that update is the first one after the clear.

// File: rtl/fdsm_pkg.sv
package fdsm_pkg;

  localparam int ACC_W  = 32;
  localparam int INT_W  = 10;
  localparam int OFF_W  = 4;
  localparam int STAGES = 3;

  typedef enum logic [1:0] {
    ORD_OFF = 2'd0,
    ORD_1   = 2'd1,
    ORD_2   = 2'd2,
    ORD_3   = 2'd3
  } ord_e;

  // lowest legal offset for a given order code
  function automatic int ofs_lo(input logic [1:0] ord);
    case (ord)
      2'd2:    return -1;
      2'd3:    return -3;
      default: return 0;
    endcase
  endfunction

  // highest legal offset for a given order code
  function automatic int ofs_hi(input logic [1:0] ord);
    case (ord)
      2'd1:    return 1;
      2'd2:    return 2;
      2'd3:    return 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/fdsm_accum.sv
module fdsm_accum #(
  parameter int ACC_W = fdsm_pkg::ACC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [1:0]       wsel_i,
  input  logic [ACC_W-1:0] add_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] nxt_o,
  output logic             carry_o
);
  localparam int STEP_W = ACC_W / 4;

  logic [ACC_W:0]   lim;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] mask;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] add_m;
  logic [ACC_W-1:0] acc_q;

  always_comb begin
    lim = '0;
    lim[STEP_W * (int'(wsel_i) + 1)] = 1'b1;
    mask    = ACC_W'(lim - 1'b1);
    base    = clr_i ? '0 : acc_q;
    add_m   = add_i & mask;
    sum     = {1'b0, base} + {1'b0, add_m};
    nxt_o   = sum[ACC_W-1:0] & mask;
    carry_o = |(sum & lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (adv_i)  acc_q <= nxt_o;
    else if (clr_i)  acc_q <= '0;
  end

  assign acc_o = acc_q;

  // R2: stored value never exceeds the selected width
  p_acc_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |-> ((acc_q & ~mask) == '0));

endmodule

// File: rtl/fdsm_shaper.sv
module fdsm_shaper #(
  parameter int OFF_W  = fdsm_pkg::OFF_W,
  parameter int STAGES = fdsm_pkg::STAGES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    adv_i,
  input  logic [1:0]              order_i,
  input  logic [STAGES-1:0]       carry_i,
  output logic signed [OFF_W-1:0] off_o
);
  logic [STAGES-1:0] ce;
  logic              c2_d, c3_d, c3_dd;
  logic              h2, h3, h33;

  function automatic logic signed [OFF_W-1:0] ext(input logic b);
    return $signed({{(OFF_W-1){1'b0}}, b});
  endfunction

  for (genvar g = 0; g < STAGES; g++) begin : g_en
    assign ce[g] = carry_i[g] & (int'(order_i) > g);
  end

  always_comb begin
    h2    = clr_i ? 1'b0 : c2_d;
    h3    = clr_i ? 1'b0 : c3_d;
    h33   = clr_i ? 1'b0 : c3_dd;
    off_o = ext(ce[0])
          + ext(ce[1]) - ext(h2)
          + ext(ce[2]) - (ext(h3) <<< 1) + ext(h33);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d <= 1'b0; c3_d <= 1'b0; c3_dd <= 1'b0;
    end else if (adv_i) begin
      c2_d <= ce[1]; c3_d <= ce[2]; c3_dd <= h3;
    end else if (clr_i) begin
      c2_d <= 1'b0; c3_d <= 1'b0; c3_dd <= 1'b0;
    end
  end

  // R5: offset confined to the span of the selected order
  p_off_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |-> (int'(off_o) >= fdsm_pkg::ofs_lo(order_i) &&
               int'(off_o) <= fdsm_pkg::ofs_hi(order_i)));

endmodule

// File: rtl/fdsm_divout.sv
module fdsm_divout #(
  parameter int INT_W = fdsm_pkg::INT_W,
  parameter int OFF_W = fdsm_pkg::OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv_i,
  input  logic [INT_W-1:0]        int_i,
  input  logic signed [OFF_W-1:0] off_i,
  output logic [INT_W-1:0]        div_o,
  output logic                    vld_o
);
  localparam int SUM_W = INT_W + 2;

  logic signed [SUM_W-1:0] raw;
  logic [INT_W-1:0]        lim_val;
  logic [INT_W-1:0]        div_q;
  logic                    vld_q;

  always_comb begin
    raw     = $signed({2'b00, int_i}) + $signed({{(SUM_W-OFF_W){off_i[OFF_W-1]}}, off_i});
    lim_val = (raw < $signed(SUM_W'(1))) ? INT_W'(1) : raw[INT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= adv_i;
      if (adv_i) div_q <= lim_val;
    end
  end

  assign div_o = div_q;
  assign vld_o = vld_q;

  // R1: one pulse per sampled strobe, value held in between
  p_vld_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> vld_o);
  p_vld_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> !vld_o);
  p_div_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(div_o));
  // R8: delivered value never below one
  p_div_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> div_o >= INT_W'(1));

endmodule

// File: rtl/fdsm_divmod.sv
module fdsm_divmod #(
  parameter int INT_W = fdsm_pkg::INT_W,
  parameter int ACC_W = fdsm_pkg::ACC_W,
  parameter int OFF_W = fdsm_pkg::OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic [INT_W-1:0] int_mult_i,
  input  logic [ACC_W-1:0] frac_k_i,
  input  logic [1:0]       wsel_i,
  input  logic [1:0]       order_i,
  output logic [INT_W-1:0] div_o,
  output logic             div_vld_o
);
  localparam int STAGES = fdsm_pkg::STAGES;

  logic [3:0]                   cfg_q;
  logic                         clr;
  logic [STAGES-1:0]            carry;
  logic [STAGES-1:0]            adv;
  logic [STAGES-1:0][ACC_W-1:0] add, nxt, acc;
  logic signed [OFF_W-1:0]      off;

  assign clr = ({wsel_i, order_i} != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {wsel_i, order_i};
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign add[g] = frac_k_i;
    end else begin : g_tail
      assign add[g] = nxt[g-1];
    end
    assign adv[g] = upd_i & (int'(order_i) > g);

    fdsm_accum #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .adv_i   (adv[g]),
      .wsel_i  (wsel_i),
      .add_i   (add[g]),
      .acc_o   (acc[g]),
      .nxt_o   (nxt[g]),
      .carry_o (carry[g])
    );
  end

  fdsm_shaper #(.OFF_W(OFF_W), .STAGES(STAGES)) u_shape (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .adv_i   (upd_i),
    .order_i (order_i),
    .carry_i (carry),
    .off_o   (off)
  );

  fdsm_divout #(.INT_W(INT_W), .OFF_W(OFF_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (upd_i),
    .int_i (int_mult_i),
    .off_i (off),
    .div_o (div_o),
    .vld_o (div_vld_o)
  );

  // R7: a configuration change with no update leaves every accumulator empty
  p_clr_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !upd_i) |=> (acc == '0));
  // R3: shaping off passes the integer straight through
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && order_i == 2'd0 && int_mult_i != '0) |=> (div_o == $past(int_mult_i)));

endmodule

// File: tb/fdsm_divmod_tb.sv
module fdsm_divmod_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0;
  logic [9:0]  im = 10'd1;
  logic [31:0] kk = '0;
  logic [1:0]  ws = 2'd0;
  logic [1:0]  os = 2'd0;
  logic [9:0]  div;
  logic        vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int ma1, ma2, ma3, mc2d, mc3d, mc3dd;

  always #10 clk = ~clk;

  fdsm_divmod dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_i      (upd),
    .int_mult_i (im),
    .frac_k_i   (kk),
    .wsel_i     (ws),
    .order_i    (os),
    .div_o      (div),
    .div_vld_o  (vld)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // reference recurrence for 8-bit width (R6)
  task automatic m_reset();
    ma1 = 0; ma2 = 0; ma3 = 0; mc2d = 0; mc3d = 0; mc3dd = 0;
  endtask

  function automatic int m_step(input int ord, input int k);
    int c1, c2, c3, y;
    ma1 = ma1 + (k & 255); c1 = ma1 >> 8; ma1 = ma1 & 255;
    ma2 = ma2 + ma1;       c2 = ma2 >> 8; ma2 = ma2 & 255;
    ma3 = ma3 + ma2;       c3 = ma3 >> 8; ma3 = ma3 & 255;
    if (ord == 2) y = c1 + c2 - mc2d;
    else          y = c1 + c2 - mc2d + c3 - 2 * mc3d + mc3dd;
    mc3dd = mc3d; mc3d = c3; mc2d = c2;
    return y;
  endfunction

  // one update; value is read half a cycle after the registering edge
  task automatic do_upd(output int val);
    @(negedge clk) upd = 1'b1;
    @(negedge clk) upd = 1'b0;
    check("R1 valid pulse", int'(vld), 1);
    val = int'(div);
  endtask

  task automatic set_cfg(input logic [1:0] w, input logic [1:0] o);
    @(negedge clk) os = 2'd0;
    @(negedge clk) begin ws = w; os = o; end
    @(negedge clk);
    m_reset();
  endtask

  task automatic t_reset();
    check("R9 reset valid", int'(vld), 0);
    check("R9 reset value", int'(div), 0);
  endtask

  task automatic t_bypass();
    int v;
    set_cfg(2'd0, 2'd0);
    im = 10'd37; kk = 32'd100;
    for (int i = 0; i < 4; i++) begin do_upd(v); check("R3 bypass", v, 37); end
    im = 10'd512;
    do_upd(v); check("R10 top of range bypass", v, 512);
  endtask

  task automatic t_idle_hold();
    int v;
    im = 10'd77;
    do_upd(v);
    im = 10'd5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 idle no pulse", int'(vld), 0);
      check("R1 idle hold", int'(div), v);
    end
  endtask

  task automatic t_first_sum();
    int v, sum, outside;
    set_cfg(2'd0, 2'd1);
    im = 10'd20; kk = 32'd77; sum = 0; outside = 0;
    for (int i = 0; i < 256; i++) begin
      do_upd(v); sum += v;
      if (v != 20 && v != 21) outside++;
    end
    check("R4 exact sum over 2^8", sum, 20 * 256 + 77);
    check("R5 order-1 span", outside, 0);
  endtask

  task automatic t_widths();
    int v;
    logic [31:0] halves [3];
    halves[0] = 32'h0000_8000; halves[1] = 32'h0080_0000; halves[2] = 32'h8000_0000;
    for (int w = 1; w < 4; w++) begin
      set_cfg(2'(w), 2'd1);
      im = 10'd100; kk = halves[w-1];
      for (int i = 0; i < 4; i++) begin
        do_upd(v); check("R2 half fraction per width", v, 100 + (i % 2));
      end
    end
    // K upper bits beyond 8 must be dropped: 0x180 behaves as 0x80
    set_cfg(2'd0, 2'd1);
    kk = 32'h0000_0180;
    for (int i = 0; i < 4; i++) begin
      do_upd(v); check("R2 upper K bits ignored", v, 100 + (i % 2));
    end
  endtask

  task automatic t_shaped(input int ord, input int n, input int k);
    int v, e, off;
    set_cfg(2'd0, 2'(ord));
    im = 10'(n); kk = 32'(k);
    for (int i = 0; i < 300; i++) begin
      do_upd(v);
      off = m_step(ord, k);
      e = (n + off < 1) ? 1 : n + off;
      check((ord == 2) ? "R6 order-2 sequence" : "R6 order-3 sequence", v, e);
      if (n + off >= 1) begin
        check("R5 offset span", int'((v - n) >= ((ord == 2) ? -1 : -3) &&
                                     (v - n) <= ((ord == 2) ? 2 : 4)), 1);
      end
    end
  endtask

  task automatic t_clear();
    int v;
    set_cfg(2'd0, 2'd1);
    im = 10'd30; kk = 32'h80;
    do_upd(v); check("R7 first step", v, 30);
    @(negedge clk) os = 2'd2;
    @(negedge clk) os = 2'd1;
    @(negedge clk);
    do_upd(v); check("R7 state cleared by order change", v, 30);
    do_upd(v); check("R7 carry after clear", v, 31);
    @(negedge clk) ws = 2'd1;
    @(negedge clk) ws = 2'd0;
    @(negedge clk);
    do_upd(v); check("R7 state cleared by width change", v, 30);
  endtask

  task automatic t_clamp();
    t_shaped(3, 1, 200);
  endtask

  task automatic t_top_shaped();
    t_shaped(3, 512, 171);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_idle_hold();
    t_first_sum();
    t_widths();
    t_shaped(2, 50, 93);
    t_shaped(3, 50, 93);
    t_clear();
    t_clamp();
    t_top_shaped();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule